// File: doc/BRIEF.md
# Set/Clear Interrupt Aggregator

The block collects single-cycle event strobes from a number of sources into a sticky pending register and drives one interrupt output pin. Each source has an enable bit. Software changes the enable mask through two write-only views: one sets the bits written as 1 and one clears them, so a driver never needs a read-modify-write. Pending bits are cleared by writing 1 to them. A global master enable gates every source. The pin can signal as a level or as a fixed-width pulse, in either polarity.

The pin is driven by a small state machine with five states. In PS_DISARMED the pin is inactive and the pin-enable bit is off or the pin was never armed. In PS_ARMED the pin is inactive and waits for an enabled pending source. In PS_LEVEL the pin is active in level mode. In PS_PULSE the pin is active for a fixed count in pulse mode. In PS_SPENT the pin is inactive after firing and waits to be re-armed.

The transitions are as follows. A configuration write with pin-enable = 1, made while every pending bit is zero, moves DISARMED or SPENT to ARMED. An enabled pending source with the master enable on moves ARMED to LEVEL or to PULSE, depending on the trigger mode. LEVEL moves to SPENT when the condition drops. PULSE moves to SPENT when its count runs out. Pin-enable = 0 returns any state to DISARMED. After a firing, software must clear all pending bits and then write pin-enable again before the pin can fire a second time.

Top module: `irq_aggregator`

## Requirements
- R1: A write to address 1 sets every enable bit whose data bit is 1 and leaves the others unchanged.
- R2: A write to address 2 clears every enable bit whose data bit is 1 and leaves the others unchanged. Reading address 1 or address 2 returns the enable mask.
- R3: An event strobe sets its pending bit whatever its enable. When an event and a clear of the same bit fall in one cycle, the bit stays set.
- R4: Reading address 0 returns the pending bits. Writing address 0 clears each pending bit whose data bit is 1.
- R5: While the master enable (configuration bit 1) is 0, no source makes the pin active. Turning the master enable on with an enabled pending source makes the pin fire.
- R6: While pin-enable (configuration bit 0) is 0, the pin is inactive. A configuration write with bit 0 = 1 arms the pin only when all pending bits are zero.
- R7: In pulse mode (configuration bit 2 = 1), a firing makes the pin active for exactly 4 clocks, two clocks after the event strobe.
- R8: In level mode, the pin stays active while an enabled bit is pending and the master enable is on. After it drops, the pin stays inactive until it is re-armed.
- R9: Configuration bit 3 = 1 makes the pin active-high. With bit 3 = 0 the pin is active-low, so it idles at 1 and reads 1 after reset.
- R10: An event on a source whose enable bit is 0 causes no pin activity.
- R11: Reading address 3 returns the four configuration bits. After reset, the configuration, enables and pending bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NSRC | One-cycle event strobes, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 pending, 1 enable set, 2 enable clear, 3 configuration |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for reg_addr (combinational) |
| irq_pin | output | 1 | Interrupt output |

## Verification
Two functions can act on the same pending bit in the same clock: a new event strobe and a software write-one-to-clear. The bench drives both in one cycle and then reads address 0, where the bit must still be set. A behavioural model runs beside the design on every clock and judges the pin and the read data against its own view of the pending, enable and firing state. That includes the arming attempt made while bits are still pending, and the count of active clocks in pulse mode.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [2:0] {
        PS_DISARMED = 3'd0,
        PS_ARMED    = 3'd1,
        PS_LEVEL    = 3'd2,
        PS_PULSE    = 3'd3,
        PS_SPENT    = 3'd4
    } pin_state_e;

    // bit 0 pin_en, bit 1 master_en, bit 2 pulse_mode, bit 3 act_high
    typedef struct packed {
        logic act_high;
        logic pulse_mode;
        logic master_en;
        logic pin_en;
    } pin_cfg_t;

    localparam int CFG_W = 4;

    localparam logic [1:0] A_STATUS = 2'd0;
    localparam logic [1:0] A_EN_SET = 2'd1;
    localparam logic [1:0] A_EN_CLR = 2'd2;
    localparam logic [1:0] A_CFG    = 2'd3;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            w1c_stb_i,
    input  logic            set_stb_i,
    input  logic            clr_stb_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] enable_o
);

    logic [NSRC-1:0] st_q;
    logic [NSRC-1:0] en_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic st_b;
        logic en_b;

        // pending: a new event wins over a software clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                st_b <= 1'b0;
            else if (evt_i[g])
                st_b <= 1'b1;
            else if (w1c_stb_i && mask_i[g])
                st_b <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_b <= 1'b0;
            else if (set_stb_i && mask_i[g])
                en_b <= 1'b1;
            else if (clr_stb_i && mask_i[g])
                en_b <= 1'b0;
        end

        assign st_q[g] = st_b;
        assign en_q[g] = en_b;
    end

    assign status_o = st_q;
    assign enable_o = en_q;

    p_evt_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_stb_i |=> ((status_o & $past(mask_i) & ~$past(evt_i)) == '0));

    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> ((enable_o & $past(mask_i)) == $past(mask_i)));

    p_set_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> ((enable_o & ~$past(mask_i)) == ($past(enable_o) & ~$past(mask_i))));

    p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_i |=> ((enable_o & $past(mask_i)) == '0));

endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [CFG_W-1:0] wdata_i,
    output pin_cfg_t         cfg_o,
    output logic             arm_req_o
);

    pin_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_stb_i)
            cfg_q <= pin_cfg_t'(wdata_i);
    end

    assign cfg_o     = cfg_q;
    assign arm_req_o = wr_stb_i && wdata_i[0];

    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(cfg_o));

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_agg_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pin_cfg_t        cfg_i,
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] enable_i,
    input  logic            arm_req_i,
    output logic            irq_pin_o
);

    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_LEN - 1);

    pin_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          qual;
    logic          all_clear;
    logic          active;

    assign qual      = cfg_i.master_en && (|(status_i & enable_i));
    assign all_clear = (status_i == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_DISARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_DISARMED, PS_SPENT: begin
                if (arm_req_i && all_clear)
                    state_d = PS_ARMED;
                else if (!cfg_i.pin_en)
                    state_d = PS_DISARMED;
            end
            PS_ARMED: begin
                if (!cfg_i.pin_en)
                    state_d = PS_DISARMED;
                else if (qual) begin
                    if (cfg_i.pulse_mode) begin
                        state_d = PS_PULSE;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = PS_LEVEL;
                    end
                end
            end
            PS_LEVEL: begin
                if (!cfg_i.pin_en)
                    state_d = PS_DISARMED;
                else if (!qual)
                    state_d = PS_SPENT;
            end
            PS_PULSE: begin
                if (!cfg_i.pin_en)
                    state_d = PS_DISARMED;
                else if (cnt_q == '0)
                    state_d = PS_SPENT;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            default: state_d = PS_DISARMED;
        endcase
    end

    // outputs
    always_comb begin
        active    = (state_q == PS_LEVEL) || (state_q == PS_PULSE);
        irq_pin_o = cfg_i.act_high ? active : !active;
    end

    p_pulse_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PULSE && cnt_q == '0 && cfg_i.pin_en) |=> (state_q == PS_SPENT));

    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LEVEL && qual && cfg_i.pin_en) |=> (state_q == PS_LEVEL));

    p_no_arm_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_DISARMED || state_q == PS_SPENT) && !all_clear) |=> (state_q != PS_ARMED));

    p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ARMED && !cfg_i.master_en) |=> !(state_q == PS_LEVEL || state_q == PS_PULSE));

    p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.pin_en && !arm_req_i) |=> (state_q == PS_DISARMED || state_q == PS_SPENT));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_strobe,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_pin
);

    localparam int PAD_W = NSRC - CFG_W;

    logic [NSRC-1:0] status;
    logic [NSRC-1:0] enable;
    pin_cfg_t        cfg;
    logic            arm_req;
    logic            w1c_stb, set_stb, clr_stb, cfg_stb;

    assign w1c_stb = reg_wr && (reg_addr == A_STATUS);
    assign set_stb = reg_wr && (reg_addr == A_EN_SET);
    assign clr_stb = reg_wr && (reg_addr == A_EN_CLR);
    assign cfg_stb = reg_wr && (reg_addr == A_CFG);

    irq_src_bank #(.NSRC(NSRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_strobe),
        .w1c_stb_i (w1c_stb),
        .set_stb_i (set_stb),
        .clr_stb_i (clr_stb),
        .mask_i    (reg_wdata),
        .status_o  (status),
        .enable_o  (enable)
    );

    irq_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (cfg_stb),
        .wdata_i   (reg_wdata[CFG_W-1:0]),
        .cfg_o     (cfg),
        .arm_req_o (arm_req)
    );

    irq_pin_fsm #(.NSRC(NSRC), .PULSE_LEN(PULSE_LEN)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .status_i  (status),
        .enable_i  (enable),
        .arm_req_i (arm_req),
        .irq_pin_o (irq_pin)
    );

    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status;
            A_EN_SET: reg_rdata = enable;
            A_EN_CLR: reg_rdata = enable;
            default:  reg_rdata = {{PAD_W{1'b0}}, cfg};
        endcase
    end

endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/100ps
module irq_aggregator_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_strobe = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_pin;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_aggregator #(.NSRC(N), .PULSE_LEN(4)) uut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin)
    );

    // behavioural reference model: 0 off, 1 waiting, 2 level, 3 pulse, 4 fired
    logic [N-1:0] m_pend, m_en;
    logic [3:0]   m_cfg;
    int           m_mode;
    int           m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_cfg = '0; m_mode = 0; m_left = 0;
        end else begin
            bit hit, arm;
            int nmode, nleft;
            hit   = m_cfg[1] && ((m_pend & m_en) != 0);
            arm   = reg_wr && reg_addr == 2'd3 && reg_wdata[0] && m_pend == 0;
            nmode = m_mode; nleft = m_left;
            if (m_mode == 0 || m_mode == 4) begin
                if (arm) nmode = 1;
                else if (!m_cfg[0]) nmode = 0;
            end else if (!m_cfg[0]) begin
                nmode = 0;
            end else if (m_mode == 1) begin
                if (hit) begin
                    if (m_cfg[2]) begin nmode = 3; nleft = 3; end
                    else nmode = 2;
                end
            end else if (m_mode == 2) begin
                if (!hit) nmode = 4;
            end else begin
                if (m_left == 0) nmode = 4; else nleft = m_left - 1;
            end
            m_mode = nmode; m_left = nleft;
            if (reg_wr && reg_addr == 2'd0) m_pend = m_pend & ~reg_wdata;
            m_pend = m_pend | evt_strobe;
            if (reg_wr && reg_addr == 2'd1) m_en = m_en | reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_en = m_en & ~reg_wdata;
            if (reg_wr && reg_addr == 2'd3) m_cfg = reg_wdata[3:0];
        end
    end

    function automatic logic model_pin();
        logic act;
        act = (m_mode == 2 || m_mode == 3);
        return m_cfg[3] ? act : !act;
    endfunction

    function automatic logic [N-1:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_pend;
            2'd1, 2'd2: return m_en;
            default: return {4'b0, m_cfg};
        endcase
    endfunction

    // per-clock comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (irq_pin !== model_pin()) begin
                errors++;
                $display("FAIL R7/R8/R9 pin model at %0t: got %0b exp %0b", $time, irq_pin, model_pin());
            end
            checks++;
            if (reg_rdata !== model_rd(reg_addr)) begin
                errors++;
                $display("FAIL R4/R2/R11 rdata model at %0t: got %h exp %h", $time, reg_rdata, model_rd(reg_addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic evt(input logic [N-1:0] m);
        @(negedge clk); #1;
        evt_strobe = m;
        @(negedge clk); #1;
        evt_strobe = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        @(negedge clk); #1;
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 / R9 reset state
        chk("R9 reset pin idle high", {7'b0, irq_pin}, 8'h01);
        rd(2'd0, v); chk("R11 reset pending", v, 8'h00);
        rd(2'd1, v); chk("R11 reset enable", v, 8'h00);
        rd(2'd3, v); chk("R11 reset config", v, 8'h00);

        // R1 / R2 enable mask
        wr(2'd1, 8'h05); wr(2'd1, 8'h0A);
        rd(2'd1, v); chk("R1 set-only accumulate", v, 8'h0F);
        wr(2'd2, 8'h03);
        rd(2'd2, v); chk("R2 clear-only", v, 8'h0C);
        rd(2'd1, v); chk("R2 read via set port", v, 8'h0C);

        // arm, level, active-low
        wr(2'd3, 8'h03);
        rd(2'd3, v); chk("R11 config readback", v, 8'h03);
        evt(8'h01); idle(3);
        rd(2'd0, v); chk("R3 disabled event latches", v, 8'h01);
        chk("R10 disabled source no pin", {7'b0, irq_pin}, 8'h01);
        evt(8'h04); idle(2);
        chk("R8 level active", {7'b0, irq_pin}, 8'h00);
        wr(2'd0, 8'h04); idle(2);
        rd(2'd0, v); chk("R4 w1c pending", v, 8'h01);
        chk("R8 level drops", {7'b0, irq_pin}, 8'h01);
        evt(8'h08); idle(3);
        chk("R8 spent until re-armed", {7'b0, irq_pin}, 8'h01);
        wr(2'd3, 8'h03); evt(8'h08); idle(3);
        chk("R6 arm refused while pending", {7'b0, irq_pin}, 8'h01);
        wr(2'd0, 8'hFF); wr(2'd3, 8'h03); evt(8'h08); idle(2);
        chk("R8 fires after re-arm", {7'b0, irq_pin}, 8'h00);

        // master enable
        wr(2'd0, 8'hFF); idle(2);
        wr(2'd3, 8'h01); evt(8'h04); idle(3);
        chk("R5 master off no pin", {7'b0, irq_pin}, 8'h01);
        wr(2'd3, 8'h03); idle(2);
        chk("R5 master on fires", {7'b0, irq_pin}, 8'h00);
        wr(2'd3, 8'h02); idle(2);
        chk("R6 pin-enable off inactive", {7'b0, irq_pin}, 8'h01);

        // pulse mode
        wr(2'd0, 8'hFF); wr(2'd3, 8'h07);
        evt(8'h04);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            if (irq_pin == 1'b0) lows++;
        end
        chk("R7 pulse width", lows[7:0], 8'd4);

        // polarity
        wr(2'd0, 8'hFF); wr(2'd3, 8'h0B); idle(2);
        chk("R9 active-high idle", {7'b0, irq_pin}, 8'h00);
        evt(8'h08); idle(2);
        chk("R9 active-high fires", {7'b0, irq_pin}, 8'h01);

        // event and clear on the same bit in one cycle
        wr(2'd0, 8'hFF);
        @(negedge clk); #1;
        evt_strobe = 8'h40; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h40;
        @(negedge clk); #1;
        evt_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, v); chk("R3 event wins over clear", v, 8'h40);

        idle(4);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule